// File: doc/BRIEF.md
# Guarded Power Mode Register

This block is a small register-bus slave that holds the power mode control word for a chip's power manager. Software selects between a running mode and a deep low-power mode and sets two autosleep enables. The mode word is protected: a write to it only lands if two fixed key words have first been written, in order, to a separate key register, with no other write in between.

The block decodes single-cycle write and read strobes with an address and 16-bit data. It tracks the unlock sequence and accepts or drops each mode write. It presents the current mode code and the two enables as outputs. When an accepted write really changes the mode code, it pulses a one-cycle commit strobe that the power sequencer downstream can act on. Read data is registered and appears the cycle after the read strobe.

Top module: `pwrg_top`

## Requirements
- R1: After reset the mode code output is 01 (running), both autosleep enables are 0, the commit strobe is 0, and a read of the mode register returns 0x0001.
- R2: A mode register write (offset 0x00) is accepted only when the key register (offset 0x04) has just received 0x4859 and then 0xF27B, in that order. The new fields show on the outputs in the cycle after the write.
- R3: A mode register write made while the guard is locked is dropped, and mode code and enables keep their values.
- R4: A key write whose value is not the expected next word returns the guard to locked. A 0xF27B that follows a wrong first word does not unlock, and a further key write after the full sequence also relocks.
- R5: A write to any address other than the mode register, made after the key sequence, returns the guard to locked.
- R6: Each completed key sequence allows exactly one mode write. The next change needs a fresh two-word sequence.
- R7: Mode write data bits [1:0] carry the mode code (01 running, 10 deep low-power). An accepted write with 00 or 11 keeps the mode code but still takes the enables: bit 2 is the timer autosleep enable and bit 3 is the sequencer-command autosleep enable.
- R8: The commit strobe is high for one cycle, in the cycle after an accepted write, only when the mode code changes.
- R9: A read returns {12 zero bits, sequencer enable, timer enable, mode code} for offset 0x00, and zero for the key register and any other address. It appears the cycle after the read strobe.
- R10: Reads never change the state of the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte offset within the block's window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| mode_code | output | 2 | Current power mode code |
| seq_sleep_en | output | 1 | Autosleep on sequencer command enabled |
| tmr_sleep_en | output | 1 | Autosleep on wake-up timer enabled |
| mode_commit | output | 1 | One-cycle pulse when the mode code changes |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, 16-bit data, mode and key registers at 0x00 and 0x04, and key words 0x4859 then 0xF27B. With these values, a third offset (0x08) stands in for any other register. Every break in the sequence can then be driven: a wrong first word, a wrong second word, a repeated first word, a foreign write and an extra key write. Reserved mode codes are written with the enable bits set differently each time. This shows that the enables land while the code holds, and that the commit strobe stays quiet when the code does not change.

// File: rtl/pwrg_pkg.sv
package pwrg_pkg;
  localparam logic [1:0] MODE_RUN  = 2'b01;
  localparam logic [1:0] MODE_DEEP = 2'b10;
  localparam int unsigned BIT_TMR  = 2;
  localparam int unsigned BIT_SEQ  = 3;
  localparam int unsigned FIELD_W  = 4;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  typedef struct packed {
    logic       seq_en;
    logic       tmr_en;
    logic [1:0] mode;
  } mode_fields_t;

  function automatic logic mode_is_legal(input logic [1:0] code);
    return (code == MODE_RUN) || (code == MODE_DEEP);
  endfunction
endpackage

// File: rtl/pwrg_key_seq.sv
module pwrg_key_seq
  import pwrg_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] KEY_A = 16'h4859,
  parameter logic [DATA_W-1:0] KEY_B = 16'hF27B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic              mode_wr,
  input  logic              other_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked
);
  key_state_e state_q, state_d;
  logic       state_en;

  assign state_en = key_wr | mode_wr | other_wr;

  always_comb begin
    state_d = state_q;
    if (mode_wr || other_wr) begin
      state_d = KS_LOCKED;
    end else if (key_wr) begin
      case (state_q)
        KS_LOCKED: state_d = (wdata == KEY_A) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (wdata == KEY_B) ? KS_OPEN : KS_LOCKED;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= KS_LOCKED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign unlocked = (state_q == KS_OPEN);

  // R2: the guard only opens right after the second key word
  assert_open_after_key_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_wr && (wdata == KEY_B)));

  // R6: a mode write always leaves the guard closed
  assert_single_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !unlocked);

  // R5: a foreign write always leaves the guard closed
  assert_foreign_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    other_wr |=> (state_q == KS_LOCKED));
endmodule

// File: rtl/pwrg_mode_reg.sv
module pwrg_mode_reg
  import pwrg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               unlocked,
  input  logic [FIELD_W-1:0] wbits,
  output mode_fields_t       fields,
  output logic               commit
);
  mode_fields_t fields_q, fields_d;
  logic         accept;
  logic         code_ok;
  logic         commit_d, commit_q;

  assign accept  = mode_wr & unlocked;
  assign code_ok = mode_is_legal(wbits[1:0]);

  always_comb begin
    fields_d        = fields_q;
    fields_d.seq_en = wbits[BIT_SEQ];
    fields_d.tmr_en = wbits[BIT_TMR];
    if (code_ok) begin
      fields_d.mode = wbits[1:0];
    end
    commit_d = accept && code_ok && (wbits[1:0] != fields_q.mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '{seq_en: 1'b0, tmr_en: 1'b0, mode: MODE_RUN};
    end else if (accept) begin
      fields_q <= fields_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_q <= 1'b0;
    end else begin
      commit_q <= commit_d;
    end
  end

  assign fields = fields_q;
  assign commit = commit_q;

  // R3: a write that is not accepted leaves every field untouched
  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode_wr && unlocked) |=> $stable(fields_q));

  // R7: a reserved code never reaches the mode output
  assert_mode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_legal(fields_q.mode));

  // R8: the commit strobe marks a real change of the mode code
  assert_commit_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (fields_q.mode != $past(fields_q.mode)));
endmodule

// File: rtl/pwrg_rd_port.sv
module pwrg_rd_port
  import pwrg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MODE_OFS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  mode_fields_t      fields,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (addr == ADDR_W'(MODE_OFS)) begin
      rdata_d[FIELD_W-1:0] = fields;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R9: reserved upper bits always read as zero
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_q[DATA_W-1:FIELD_W] == '0);
endmodule

// File: rtl/pwrg_top.sv
module pwrg_top
  import pwrg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MODE_OFS = 0,
  parameter int unsigned KEY_OFS  = 4,
  parameter logic [DATA_W-1:0] KEY_A = 16'h4859,
  parameter logic [DATA_W-1:0] KEY_B = 16'hF27B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        mode_code,
  output logic              seq_sleep_en,
  output logic              tmr_sleep_en,
  output logic              mode_commit
);
  logic         hit_mode, hit_key;
  logic         mode_wr, key_wr, other_wr;
  logic         unlocked;
  mode_fields_t fields;

  assign hit_mode = (addr == ADDR_W'(MODE_OFS));
  assign hit_key  = (addr == ADDR_W'(KEY_OFS));
  assign mode_wr  = wr_en & hit_mode;
  assign key_wr   = wr_en & hit_key;
  assign other_wr = wr_en & ~hit_mode & ~hit_key;

  pwrg_key_seq #(
    .DATA_W (DATA_W),
    .KEY_A  (KEY_A),
    .KEY_B  (KEY_B)
  ) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .mode_wr  (mode_wr),
    .other_wr (other_wr),
    .wdata    (wdata),
    .unlocked (unlocked)
  );

  pwrg_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .unlocked (unlocked),
    .wbits    (wdata[FIELD_W-1:0]),
    .fields   (fields),
    .commit   (mode_commit)
  );

  pwrg_rd_port #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MODE_OFS (MODE_OFS)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .addr   (addr),
    .fields (fields),
    .rdata  (rdata)
  );

  assign mode_code    = fields.mode;
  assign seq_sleep_en = fields.seq_en;
  assign tmr_sleep_en = fields.tmr_en;

  // R10: a read alone never opens the guard
  assert_read_no_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !unlocked) |=> !unlocked);
endmodule

// File: tb/pwrg_top_test.sv
`timescale 1ns/1ps
module pwrg_top_test;
  logic        clk;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  mode_code;
  logic        seq_sleep_en, tmr_sleep_en, mode_commit;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  pwrg_top uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .mode_code    (mode_code),
    .seq_sleep_en (seq_sleep_en),
    .tmr_sleep_en (tmr_sleep_en),
    .mode_commit  (mode_commit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req[3:0], addr[7:0], data[15:0], mode[1:0], seq, tmr, commit}
  localparam int NV = 37;
  localparam logic [32:0] VEC [NV] = '{
    {4'd2, 8'h04, 16'h4859, 2'b01, 1'b0, 1'b0, 1'b0}, // R2 first word
    {4'd2, 8'h04, 16'hF27B, 2'b01, 1'b0, 1'b0, 1'b0}, // R2 second word
    {4'd2, 8'h00, 16'h0002, 2'b10, 1'b0, 1'b0, 1'b1}, // R2 accepted, R8 commit
    {4'd3, 8'h00, 16'h0001, 2'b10, 1'b0, 1'b0, 1'b0}, // R3 locked drop
    {4'd4, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b0, 1'b0}, // R4 wrong first
    {4'd4, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 8'h00, 16'h0001, 2'b10, 1'b0, 1'b0, 1'b0}, // R4 still locked
    {4'd4, 8'h04, 16'h4859, 2'b10, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 8'h04, 16'h1234, 2'b10, 1'b0, 1'b0, 1'b0}, // R4 wrong second
    {4'd4, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b0, 1'b0}, // R4
    {4'd4, 8'h00, 16'h0001, 2'b10, 1'b0, 1'b0, 1'b0}, // R4 dropped
    {4'd5, 8'h04, 16'h4859, 2'b10, 1'b0, 1'b0, 1'b0}, // R5
    {4'd5, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b0, 1'b0}, // R5
    {4'd5, 8'h08, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b0}, // R5 foreign write
    {4'd5, 8'h00, 16'h0001, 2'b10, 1'b0, 1'b0, 1'b0}, // R5 dropped
    {4'd7, 8'h04, 16'h4859, 2'b10, 1'b0, 1'b0, 1'b0}, // R7
    {4'd7, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b0, 1'b0}, // R7
    {4'd7, 8'h00, 16'h000F, 2'b10, 1'b1, 1'b1, 1'b0}, // R7 code 11
    {4'd7, 8'h04, 16'h4859, 2'b10, 1'b1, 1'b1, 1'b0}, // R7
    {4'd7, 8'h04, 16'hF27B, 2'b10, 1'b1, 1'b1, 1'b0}, // R7
    {4'd7, 8'h00, 16'h0000, 2'b10, 1'b0, 1'b0, 1'b0}, // R7 code 00
    {4'd8, 8'h04, 16'h4859, 2'b10, 1'b0, 1'b0, 1'b0}, // R8
    {4'd8, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b0, 1'b0}, // R8
    {4'd8, 8'h00, 16'h0006, 2'b10, 1'b0, 1'b1, 1'b0}, // R8 same code
    {4'd8, 8'h04, 16'h4859, 2'b10, 1'b0, 1'b1, 1'b0}, // R8
    {4'd8, 8'h04, 16'hF27B, 2'b10, 1'b0, 1'b1, 1'b0}, // R8
    {4'd8, 8'h00, 16'h0009, 2'b01, 1'b1, 1'b0, 1'b1}, // R8 change
    {4'd6, 8'h00, 16'h0002, 2'b01, 1'b1, 1'b0, 1'b0}, // R6 reuse dropped
    {4'd4, 8'h04, 16'h4859, 2'b01, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 8'h04, 16'h4859, 2'b01, 1'b1, 1'b0, 1'b0}, // R4 repeat first
    {4'd4, 8'h04, 16'hF27B, 2'b01, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 8'h00, 16'h0002, 2'b01, 1'b1, 1'b0, 1'b0}, // R4 dropped
    {4'd4, 8'h04, 16'h4859, 2'b01, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 8'h04, 16'hF27B, 2'b01, 1'b1, 1'b0, 1'b0}, // R4 open
    {4'd4, 8'h04, 16'h4859, 2'b01, 1'b1, 1'b0, 1'b0}, // R4 extra key relocks
    {4'd4, 8'h04, 16'hF27B, 2'b01, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 8'h00, 16'h0002, 2'b01, 1'b1, 1'b0, 1'b0}  // R4 dropped
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [1:0] em, input logic es,
                           input logic et, input logic ec);
    check(req, {11'd0, mode_code, seq_sleep_en, tmr_sleep_en, mode_commit},
          {11'd0, em, es, et, ec});
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    check_out("R1", 2'b01, 1'b0, 1'b0, 1'b0);
    check("R1", rdata, 16'h0000);
    do_read(8'h00);
    check("R1", rdata, 16'h0001);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][28:21], VEC[i][20:5]);
      check_out($sformatf("R%0d vec %0d", VEC[i][32:29], i),
                VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R9 read of the mode register after the table: seq=1 tmr=0 mode=01
    do_read(8'h00);
    check("R9 mode readback", rdata, 16'h0009);
    do_read(8'h04);
    check("R9 key reads zero", rdata, 16'h0000);

    // R10 reads between key words keep the sequence alive
    do_write(8'h04, 16'h4859);
    do_read(8'h00);
    check("R10 read mid-sequence", rdata, 16'h0009);
    do_write(8'h04, 16'hF27B);
    do_read(8'h08);
    check("R9 other address reads zero", rdata, 16'h0000);
    do_write(8'h00, 16'hFFF6);
    check_out("R10 write accepted after reads", 2'b10, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check_out("R8 strobe lasts one cycle", 2'b10, 1'b0, 1'b1, 1'b0);
    do_read(8'h00);
    check("R9 reserved bits zero", rdata, 16'h0006);

    // R1 reset mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after reset", 2'b01, 1'b0, 1'b0, 1'b0);

    finish_run();
  end
endmodule